// File: doc/BRIEF.md
# Banked Static Word Memory

This block is a clocked, synthesizable stand-in for a static word memory that is assembled from four byte-wide banks. The banks form two pairs. Within a pair, one bank holds the low byte of each word and the other holds the high byte. The most significant address bit goes through a decoder that enables exactly one pair. The remaining address bits go to every bank.

The host side follows the usual pins of an asynchronous memory: active-low chip select, write enable and output enable, an address, and a data bus. The bidirectional bus is split into a data input, a data output and an output-enable flag that says when the block would drive the bus. The inputs are sampled on the rising clock edge.

A write is the span of cycles during which chip select and write enable are both low. The address and data are captured on each cycle of that span. The last captured pair is committed on the edge at which the span is first seen to have ended. Memory contents are undefined after reset.

The full 64K-word part uses `ADDR_W = 16`. The default is a reduced depth, so that elaboration stays small.

Top module: `sram_banked_module`

## Requirements
- R1: While reset is held and on the first cycle after it, `dout_oe` is 0 and `dout` is 0.
- R2: When `cs_n` is 1 at a sampling edge, `dout_oe` is 0 after that edge, whatever `we_n` and `oe_n` are (standby).
- R3: When `cs_n` = 0 and `we_n` = 0 at an edge, `dout_oe` is 0 after that edge, even with `oe_n` = 0 (write mode; the bus is an input).
- R4: When `cs_n` = 0, `oe_n` = 0 and `we_n` = 1 at an edge, after that edge `dout_oe` is 1 and `dout` holds the word last written to `addr` (read mode, one cycle of latency).
- R5: When `cs_n` = 0, `oe_n` = 1 and `we_n` = 1 at an edge, `dout_oe` is 0 after that edge (outputs disabled).
- R6: Holding `we_n` low while `cs_n` is high writes nothing; a later read of that address returns its earlier contents.
- R7: A write span commits only the address and data sampled on its last low-low cycle. Addresses presented earlier in the same span keep their old words. The span ends when either `cs_n` or `we_n` goes high.
- R8: Address bit `ADDR_W-1` selects one of two bank pairs. Two addresses that differ only in that bit hold independent words. Bits 7:0 and 15:8 of each word are kept in separate banks and are returned unchanged.
- R9: A read on the edge that commits a write to the same address returns the newly committed word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address; top bit picks the bank pair |
| din | input | 16 | Write data (bus in) |
| dout | output | 16 | Read data (bus out), 0 when not driven |
| dout_oe | output | 1 | 1 when the block drives the bus |

## Verification
The bench builds the block with `ADDR_W = 6`, which gives 64 words split into two pairs of 32 rows. At that size, every address can be written with a distinct arithmetic pattern and read back, so both pair-select values and both byte lanes are covered exhaustively. The small depth also leaves room to walk all four combinations of the control pins in standby, and to place multi-cycle write spans, a write that is blocked by chip select, and a same-edge commit-and-read next to known contents.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_WRITE   = 2'd2,
    MODE_OUTOFF  = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_mode_dec.sv
module sram_mode_dec
  import sram_pkg::*;
(
  input  logic       cs_n,
  input  logic       we_n,
  input  logic       oe_n,
  output sram_mode_e mode
);
  // Chip select dominates, then write enable, then output enable.
  always_comb begin
    if (cs_n)      mode = MODE_STANDBY;
    else if (!we_n) mode = MODE_WRITE;
    else if (!oe_n) mode = MODE_READ;
    else           mode = MODE_OUTOFF;
  end
endmodule

// File: rtl/sram_pair_dec.sv
module sram_pair_dec #(
  parameter int SEL_W = 1,
  localparam int NUM  = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel,
  input  logic             en,
  output logic [NUM-1:0]   hit
);
  for (genvar i = 0; i < NUM; i++) begin : g_out
    assign hit[i] = en && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/sram_byte_bank.sv
module sram_byte_bank #(
  parameter int ROW_W  = 9,
  parameter int BYTE_W = 8,
  localparam int ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ROW_W-1:0]  waddr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              re,
  input  logic [ROW_W-1:0]  raddr,
  output logic [BYTE_W-1:0] rdata
);
  logic [BYTE_W-1:0] cells [0:ROWS-1];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/sram_banked_module.sv
module sram_banked_module
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int BYTE_W = 8,
  parameter int LANES  = 2,
  localparam int DATA_W = BYTE_W * LANES,
  localparam int SEL_W  = 1,
  localparam int ROW_W  = ADDR_W - SEL_W,
  localparam int PAIRS  = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);
  sram_mode_e mode;
  logic       in_write, in_read, commit;
  logic       span_q, oe_q, byp_q;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_data, byp_data_q;
  logic [SEL_W-1:0]  rd_pair_q;
  logic [PAIRS-1:0]  pair_we, pair_re;
  logic [DATA_W-1:0] pair_rd [PAIRS];

  sram_mode_dec u_mode (
    .cs_n (cs_n),
    .we_n (we_n),
    .oe_n (oe_n),
    .mode (mode)
  );

  assign in_write = (mode == MODE_WRITE);
  assign in_read  = (mode == MODE_READ);
  // The write span ends on the first sampled cycle without the low-low overlap.
  assign commit   = span_q && !in_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_q <= 1'b0;
      oe_q   <= 1'b0;
      byp_q  <= 1'b0;
    end else begin
      span_q <= in_write;
      oe_q   <= in_read;
      byp_q  <= commit && in_read && (lat_addr == addr);
    end
  end

  always_ff @(posedge clk) begin
    if (in_write) begin
      lat_addr <= addr;
      lat_data <= din;
    end
    if (in_read) rd_pair_q <= addr[ADDR_W-1 -: SEL_W];
    byp_data_q <= lat_data;
  end

  sram_pair_dec #(.SEL_W(SEL_W)) u_wdec (
    .sel (lat_addr[ADDR_W-1 -: SEL_W]),
    .en  (commit),
    .hit (pair_we)
  );

  sram_pair_dec #(.SEL_W(SEL_W)) u_rdec (
    .sel (addr[ADDR_W-1 -: SEL_W]),
    .en  (in_read),
    .hit (pair_re)
  );

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      sram_byte_bank #(.ROW_W(ROW_W), .BYTE_W(BYTE_W)) u_bank (
        .clk   (clk),
        .we    (pair_we[p]),
        .waddr (lat_addr[ROW_W-1:0]),
        .wdata (lat_data[l*BYTE_W +: BYTE_W]),
        .re    (pair_re[p]),
        .raddr (addr[ROW_W-1:0]),
        .rdata (pair_rd[p][l*BYTE_W +: BYTE_W])
      );
    end
  end

  assign dout_oe = oe_q;
  assign dout    = oe_q ? (byp_q ? byp_data_q : pair_rd[rd_pair_q]) : '0;

  a_r2_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dout_oe);
  a_r3_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !we_n) |=> !dout_oe);
  a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && we_n) |=> dout_oe);
  a_r5_outoff_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && oe_n && we_n) |=> !dout_oe);
  a_r1_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> (dout == '0));
endmodule

// File: tb/sram_banked_module_test.sv
module sram_banked_module_test;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic dout_oe;
  int checks = 0, errors = 0;
  logic [15:0] model [WORDS];

  always #2 clk = ~clk;

  sram_banked_module #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [15:0] pat(input int a, input int salt);
    return 16'((a * 40503) ^ (a << 9) ^ salt);
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o,
                      input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    cs_n = c; we_n = w; oe_n = o; addr = a; din = d;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
    step(0, 0, 1, a, d);
    step(1, 1, 1, '0, '0);
    model[a] = d;
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] a, input logic [15:0] exp);
    step(0, 1, 0, a, '0);
    @(negedge clk);
    chk({tag, " oe"}, 16'(dout_oe), 16'd1);
    chk({tag, " data"}, dout, exp);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset oe", 16'(dout_oe), 16'd0);
    chk("R1 reset dout", dout, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 post-reset oe", 16'(dout_oe), 16'd0);

    // R8: every address, both pairs, both lanes
    for (int a = 0; a < WORDS; a++) wr(AW'(a), pat(a, 16'h5AC3));
    for (int a = 0; a < WORDS; a++) rd("R4 R8 sweep", AW'(a), model[a]);

    // R2: standby with all we/oe combinations
    for (int k = 0; k < 4; k++) begin
      step(1, k[0], k[1], AW'(k), 16'hFFFF);
      @(negedge clk);
      chk("R2 standby oe", 16'(dout_oe), 16'd0);
      chk("R2 standby dout", dout, 16'd0);
    end
    step(1, 1, 1, '0, '0);

    // R5: outputs disabled
    step(0, 1, 1, AW'(3), '0);
    @(negedge clk);
    chk("R5 outoff oe", 16'(dout_oe), 16'd0);

    // R3: write with oe low still not driven
    step(0, 0, 0, AW'(7), 16'hBEEF);
    @(negedge clk);
    chk("R3 write oe", 16'(dout_oe), 16'd0);
    step(1, 1, 1, '0, '0);
    model[7] = 16'hBEEF;
    rd("R3 stored", AW'(7), 16'hBEEF);

    // R6: we low with cs high writes nothing
    step(1, 0, 1, AW'(9), 16'h1234);
    step(1, 0, 1, AW'(9), 16'h1234);
    step(1, 1, 1, '0, '0);
    rd("R6 blocked", AW'(9), model[9]);

    // R7: multi-cycle span, last sample wins, ended by cs rising
    step(0, 0, 1, AW'(12), 16'hAAAA);
    step(0, 0, 1, AW'(44), 16'hBBBB);
    step(0, 0, 1, AW'(20), 16'hCCCC);
    step(1, 0, 1, '0, '0);
    step(1, 1, 1, '0, '0);
    model[20] = 16'hCCCC;
    rd("R7 last", AW'(20), 16'hCCCC);
    rd("R7 first kept", AW'(12), model[12]);
    rd("R7 middle kept", AW'(44), model[44]);

    // R8: addresses differing in top bit are independent
    wr(AW'(5), 16'h00FF);
    wr(AW'(5 + WORDS / 2), 16'hFF00);
    rd("R8 low pair", AW'(5), 16'h00FF);
    rd("R8 high pair", AW'(5 + WORDS / 2), 16'hFF00);

    // R9: read on the commit edge of the same address
    step(0, 0, 1, AW'(33), 16'h7E81);
    step(0, 1, 0, AW'(33), '0);
    @(negedge clk);
    model[33] = 16'h7E81;
    chk("R9 bypass oe", 16'(dout_oe), 16'd1);
    chk("R9 bypass data", dout, 16'h7E81);
    rd("R9 stored", AW'(33), 16'h7E81);

    step(1, 1, 1, '0, '0);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule